// File: doc/BRIEF.md
# Decimating FIR/IIR Multiply-Accumulate Filter

This block is a programmable digital filter that uses a single multiply-accumulate datapath for two kinds of filter. It works either as a 9-tap finite-response filter or as a 4th-order recursive filter with 5 forward and 4 feedback terms. Each 16-bit signed sample arrives on a valid/ready handshake and is pushed into the tap history. The block then walks the nine coefficient/tap pairs, one product per clock, into a 51-bit accumulator. The sum is reduced to 16 bits with round-half-to-even. A result that does not fit in 16 bits either wraps or saturates, as configured.

Results are thinned by an integer factor from 1 to 16. Every accepted sample still advances the filter state. Three mode inputs select run, hold or off. A flush input clears the history. A prefill input loads samples into the history without computing anything, which lets the filter settle before real output starts.

Coefficients are 24-bit signed values with 23 fraction bits. The filter writes them through a simple write port. In recursive mode the feedback history keeps the sum rounded to 24 bits, with 8 fraction bits, so fine detail is not lost between iterations.

Top module: `dfilt_top`

## Requirements
- R1: With `cfg_iir`=0, coefficient address k (0..8) weights the sample k inputs back (k=0 is the newest), acc = sum c[k]*x[n-k], and `out_data` = acc reduced at fraction position 23 (R3, R4).
- R2: With `cfg_iir`=1, addresses 0..4 are forward weights on x[n..n-4] and addresses 5..8 are feedback weights on w[n-1..n-4]. Each feedback product c*w is arithmetically shifted right by 8 before it is added. w = acc reduced at fraction position 15 to 24 bits. It is stored after each computed sample, and a flush clears it.
- R3: Reduction rounds to nearest. A remainder of exactly one half rounds toward the even quotient.
- R4: `cfg_sat`=0 keeps the low 16 (or 24) bits of an out-of-range result. `cfg_sat`=1 clamps it to 32767 / -32768, or to the 24-bit limits for w.
- R5: With `cfg_dec`=D, one result is emitted for the (D+1)-th computed sample after reset or flush, and for every (D+1)-th one after that. Every accepted sample updates the history.
- R6: `out_valid` is a one-cycle pulse on the 11th rising edge after the accepting edge, unless a hold intervenes. `in_ready` returns in that same cycle. The bound is 58 cycles.
- R7: Mode decode of (`mdis`,`fren`,`frz`): `mdis`=1 is off, (0,1,1) is hold, and every other combination is run. `in_ready` is high only in run mode with the block idle and no flush.
- R8: In hold mode, no sample is accepted and all state is kept: history, computation in progress, decimation count and coefficients. Coefficient writes and flush are ignored. A computation in progress resumes when the block leaves hold mode and finishes late by exactly the number of held cycles.
- R9: In off mode, `in_ready` is low and any computation in progress is dropped without output or feedback update. A sample already accepted stays in the history. Coefficient writes take effect.
- R10: A flush pulse (outside hold mode) zeroes both histories and the decimation count, and drops any computation in progress.
- R11: A sample accepted while `prefill`=1 shifts into the forward history only. It produces no output and leaves the decimation count unchanged, and `in_ready` stays high.
- R12: After reset, `out_valid` is 0, both histories and the decimation count are zero, and in run mode `in_ready` is 1. Coefficients are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mdis | input | 1 | Mode bit: off when 1 |
| fren | input | 1 | Mode bit: hold enable |
| frz | input | 1 | Mode bit: hold request |
| cfg_iir | input | 1 | 1 = recursive, 0 = finite response |
| cfg_sat | input | 1 | 1 = saturate, 0 = wrap |
| cfg_dec | input | 4 | Decimation factor minus one |
| prefill | input | 1 | Load history without computing |
| flush | input | 1 | Clear history and decimation count |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 4 | Coefficient index 0..8 |
| coef_wdata | input | 24 | Coefficient value, signed, 23 fraction bits |
| in_valid | input | 1 | Sample valid |
| in_data | input | 16 | Sample, signed |
| in_ready | output | 1 | Sample can be taken |
| out_valid | output | 1 | Result pulse |
| out_data | output | 16 | Result, signed |

## Verification
The assertions assume that coefficients and configuration (`cfg_iir`, `cfg_sat`, `cfg_dec`) stay still while a sample is being processed. They also assume that the 51-bit accumulator never wraps. The stimulus changes configuration and coefficients only between samples, after the previous result window has passed. It keeps coefficient and sample magnitudes at a level where nine products cannot reach 2^50. Hold and off periods are applied in the middle of a computation. Flushes are issued only while the block is idle or held, so the bench model can follow every state change.

// File: rtl/dfilt_pkg.sv
package dfilt_pkg;
  typedef enum logic [1:0] {
    MD_RUN  = 2'd0,
    MD_HOLD = 2'd1,
    MD_OFF  = 2'd2
  } mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2,
    ST_FIN   = 2'd3
  } step_e;
endpackage

// File: rtl/dfilt_mode.sv
module dfilt_mode
  import dfilt_pkg::*;
(
  input  logic  mdis,
  input  logic  fren,
  input  logic  frz,
  output mode_e mode
);
  // R7: off wins, hold needs both enable and request
  always_comb begin
    if (mdis)              mode = MD_OFF;
    else if (fren && frz)  mode = MD_HOLD;
    else                   mode = MD_RUN;
  end
endmodule

// File: rtl/dfilt_coef_ram.sv
module dfilt_coef_ram #(
  parameter int CW    = 24,
  parameter int DEPTH = 9,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [CW-1:0] rd_data
);
  logic [CW-1:0] mem [DEPTH];

  // single write port, registered read: fits an inferred RAM
  always_ff @(posedge clk) begin
    if (wr_en && (int'(wr_addr) < DEPTH))
      mem[wr_addr] <= wr_data;
    if (rd_en)
      rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/dfilt_taps.sv
module dfilt_taps #(
  parameter int DW   = 16,
  parameter int FBW  = 24,
  parameter int TW   = 24,
  parameter int NFF  = 9,
  parameter int NIFF = 5,
  parameter int NIFB = 4,
  parameter int SW   = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  hold,
  input  logic                  clr,
  input  logic                  ff_push,
  input  logic signed [DW-1:0]  ff_in,
  input  logic                  fb_push,
  input  logic signed [FBW-1:0] fb_in,
  input  logic                  iir,
  input  logic [SW-1:0]         sel,
  output logic signed [TW-1:0]  tap_o,
  output logic                  tap_fb
);
  logic signed [DW-1:0]  ff_q [NFF];
  logic signed [FBW-1:0] fb_q [NIFB];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int i = 0; i < NFF; i++)  ff_q[i] <= '0;
      for (int j = 0; j < NIFB; j++) fb_q[j] <= '0;
    end else if (!hold) begin
      if (ff_push) begin
        ff_q[0] <= ff_in;
        for (int i = 1; i < NFF; i++) ff_q[i] <= ff_q[i-1];
      end
      if (fb_push) begin
        fb_q[0] <= fb_in;
        for (int j = 1; j < NIFB; j++) fb_q[j] <= fb_q[j-1];
      end
    end
  end

  // operand select: forward taps first, feedback taps after them in recursive mode
  always_comb begin
    tap_o  = '0;
    tap_fb = iir && (int'(sel) >= NIFF);
    for (int i = 0; i < NFF; i++)
      if ((int'(sel) == i) && !(iir && i >= NIFF))
        tap_o = {{(TW-DW){ff_q[i][DW-1]}}, ff_q[i]};
    for (int j = 0; j < NIFB; j++)
      if (iir && (int'(sel) == NIFF + j))
        tap_o = {{(TW-FBW){fb_q[j][FBW-1]}}, fb_q[j]};
  end

  // R10: a flush leaves both histories empty
  a_r10_flush_clears: assert property (@(posedge clk) disable iff (rst)
    clr |=> (ff_q[0] == '0) && (fb_q[0] == '0));
endmodule

// File: rtl/dfilt_reduce.sv
module dfilt_reduce #(
  parameter int IW = 51,
  parameter int SH = 23,
  parameter int OW = 16
) (
  input  logic signed [IW-1:0] acc,
  input  logic                 sat,
  output logic signed [OW-1:0] res
);
  localparam int QW = IW - SH + 1;
  localparam logic [SH-1:0] HALF = SH'(1) << (SH - 1);
  localparam logic signed [OW-1:0] OMAX = {1'b0, {(OW-1){1'b1}}};
  localparam logic signed [OW-1:0] OMIN = {1'b1, {(OW-1){1'b0}}};

  logic [QW-1:0] q, qr;
  logic [SH-1:0] rem;
  logic          up, fits;

  always_comb begin
    q    = {acc[IW-1], acc[IW-1:SH]};
    rem  = acc[SH-1:0];
    // R3: half goes to the even neighbour
    up   = (rem > HALF) || ((rem == HALF) && acc[SH]);
    qr   = q + {{(QW-1){1'b0}}, up};
    fits = (&qr[QW-1:OW-1]) || !(|qr[QW-1:OW-1]);
    if (fits || !sat) res = qr[OW-1:0];
    else if (qr[QW-1]) res = OMIN;
    else               res = OMAX;
  end
endmodule

// File: rtl/dfilt_top.sv
module dfilt_top
  import dfilt_pkg::*;
#(
  parameter int DW      = 16,
  parameter int CW      = 24,
  parameter int FBW     = 24,
  parameter int AW      = 51,
  parameter int FRAC    = 23,
  parameter int NFF     = 9,
  parameter int NIFF    = 5,
  parameter int NIFB    = 4,
  parameter int DECW    = 4,
  parameter int MAX_LAT = 58
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 mdis,
  input  logic                 fren,
  input  logic                 frz,
  input  logic                 cfg_iir,
  input  logic                 cfg_sat,
  input  logic [DECW-1:0]      cfg_dec,
  input  logic                 prefill,
  input  logic                 flush,
  input  logic                 coef_we,
  input  logic [3:0]           coef_addr,
  input  logic [CW-1:0]        coef_wdata,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  output logic                 in_ready,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_data
);
  localparam int NIT   = NIFF + NIFB;
  localparam int CDEP  = (NFF > NIT) ? NFF : NIT;
  localparam int CAW   = $clog2(CDEP);
  localparam int TW    = (CW > FBW) ? CW : FBW;
  localparam int PW    = CW + TW;
  localparam int FBGAP = FBW - DW;
  localparam int FB_SH = FRAC - FBGAP;
  localparam int LATW  = $clog2(MAX_LAT + 1);

  mode_e mode;
  step_e st;
  logic  frozen, off, accept, calc, fin_go;

  logic [CAW-1:0]         idx, last_idx;
  logic [CW-1:0]          coef_raw;
  logic signed [TW-1:0]   tap_sel, tap_q;
  logic                   sel_fb, fb_q;
  logic                   pv;
  logic signed [PW-1:0]   prod, prod_adj;
  logic signed [AW-1:0]   acc;
  logic signed [DW-1:0]   y_val;
  logic signed [FBW-1:0]  w_val;
  logic [DECW-1:0]        dcnt;
  logic [LATW-1:0]        lat;

  dfilt_mode u_mode (.mdis(mdis), .fren(fren), .frz(frz), .mode(mode));

  assign frozen   = (mode == MD_HOLD);
  assign off      = (mode == MD_OFF);
  assign in_ready = (st == ST_IDLE) && (mode == MD_RUN) && !flush;
  assign accept   = in_valid && in_ready;
  assign calc     = accept && !prefill;
  assign last_idx = cfg_iir ? CAW'(NIT - 1) : CAW'(NFF - 1);
  assign fin_go   = (st == ST_FIN) && !frozen && !off && !flush;

  dfilt_coef_ram #(.CW(CW), .DEPTH(CDEP), .AW(CAW)) u_coef (
    .clk     (clk),
    .wr_en   (coef_we && !frozen),
    .wr_addr (coef_addr[CAW-1:0]),
    .wr_data (coef_wdata),
    .rd_en   (!frozen),
    .rd_addr (idx),
    .rd_data (coef_raw)
  );

  dfilt_taps #(.DW(DW), .FBW(FBW), .TW(TW), .NFF(NFF), .NIFF(NIFF),
               .NIFB(NIFB), .SW(CAW)) u_taps (
    .clk     (clk),
    .rst     (rst),
    .hold    (frozen),
    .clr     (flush && !frozen),
    .ff_push (accept),
    .ff_in   (in_data),
    .fb_push (fin_go && cfg_iir),
    .fb_in   (w_val),
    .iir     (cfg_iir),
    .sel     (idx),
    .tap_o   (tap_sel),
    .tap_fb  (sel_fb)
  );

  // feedback operands carry FBGAP more fraction bits than forward ones
  always_comb begin
    prod     = $signed(coef_raw) * tap_q;
    prod_adj = fb_q ? (prod >>> FBGAP) : prod;
  end

  dfilt_reduce #(.IW(AW), .SH(FRAC), .OW(DW)) u_red_out (
    .acc(acc), .sat(cfg_sat), .res(y_val));

  dfilt_reduce #(.IW(AW), .SH(FB_SH), .OW(FBW)) u_red_fb (
    .acc(acc), .sat(cfg_sat), .res(w_val));

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      idx       <= '0;
      pv        <= 1'b0;
      tap_q     <= '0;
      fb_q      <= 1'b0;
      acc       <= '0;
      dcnt      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (frozen) begin
        // hold: nothing moves
      end else if (flush || off) begin
        st <= ST_IDLE;
        pv <= 1'b0;
        if (flush) dcnt <= '0;
      end else begin
        if (pv)
          acc <= acc + {{(AW-PW){prod_adj[PW-1]}}, prod_adj};
        unique case (st)
          ST_IDLE: begin
            if (calc) begin
              idx <= '0;
              acc <= '0;
              st  <= ST_RUN;
            end
          end
          ST_RUN: begin
            tap_q <= tap_sel;
            fb_q  <= sel_fb;
            pv    <= 1'b1;
            if (idx == last_idx) st <= ST_DRAIN;
            else                 idx <= idx + 1'b1;
          end
          ST_DRAIN: begin
            pv <= 1'b0;
            st <= ST_FIN;
          end
          ST_FIN: begin
            st <= ST_IDLE;
            if (dcnt >= cfg_dec) begin
              dcnt      <= '0;
              out_valid <= 1'b1;
              out_data  <= y_val;
            end else begin
              dcnt <= dcnt + 1'b1;
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  // busy-cycle counter used only to check the latency bound
  always_ff @(posedge clk) begin
    if (rst || st == ST_IDLE) lat <= '0;
    else if (!frozen && lat != LATW'(MAX_LAT)) lat <= lat + 1'b1;
  end

  // R6: a computation never runs longer than the bound
  a_r6_latency: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE) |-> (lat < LATW'(MAX_LAT)));

  // R8: hold freezes the sequencer and the accumulator
  a_r8_hold_still: assert property (@(posedge clk) disable iff (rst)
    frozen |=> $stable(st) && $stable(idx) && $stable(acc) && $stable(dcnt));

  // R9: off mode emits nothing
  a_r9_off_quiet: assert property (@(posedge clk) disable iff (rst)
    off |=> !out_valid);

  // R11: a prefill sample starts no computation
  a_r11_prefill_silent: assert property (@(posedge clk) disable iff (rst)
    (accept && prefill) |=> (st == ST_IDLE) && !out_valid);
endmodule

// File: tb/dfilt_top_tb_top.sv
`timescale 1ns/1ps
module dfilt_top_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mdis = 0, fren = 0, frz = 0;
  logic cfg_iir = 0, cfg_sat = 0;
  logic [3:0] cfg_dec = '0;
  logic prefill = 0, flush = 0;
  logic coef_we = 0;
  logic [3:0] coef_addr = '0;
  logic [23:0] coef_wdata = '0;
  logic in_valid = 0;
  logic signed [15:0] in_data = '0;
  logic in_ready, out_valid;
  logic signed [15:0] out_data;

  always #2 clk = ~clk;

  dfilt_top dut_i (
    .clk(clk), .rst(rst), .mdis(mdis), .fren(fren), .frz(frz),
    .cfg_iir(cfg_iir), .cfg_sat(cfg_sat), .cfg_dec(cfg_dec),
    .prefill(prefill), .flush(flush), .coef_we(coef_we),
    .coef_addr(coef_addr), .coef_wdata(coef_wdata),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data));

  int n_vec = 0, n_fail = 0;
  bit done = 0;
  int unsigned seed = 32'h1234_5678;

  // bench model state
  longint cf [9];
  longint mff [9];
  longint mfb [4];
  int mdc = 0;
  bit m_iir = 0, m_sat = 0;
  int m_dec = 0;

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rnd(int span);
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 8) % (2 * span + 1)) - span;
  endfunction

  function automatic longint reduce(longint a, int sh, int ow, bit sat);
    longint q, rem, half, mx, mn;
    q    = a >>> sh;
    rem  = a & ((64'sd1 <<< sh) - 1);
    half = 64'sd1 <<< (sh - 1);
    if (rem > half || (rem == half && q[0])) q = q + 1;
    mx = (64'sd1 <<< (ow - 1)) - 1;
    mn = -(64'sd1 <<< (ow - 1));
    if (q > mx || q < mn) begin
      if (sat) q = (q > mx) ? mx : mn;
      else begin
        q = q & ((64'sd1 <<< ow) - 1);
        if (q[ow-1]) q = q - (64'sd1 <<< ow);
      end
    end
    return q;
  endfunction

  function automatic void m_push(longint x);
    for (int i = 8; i > 0; i--) mff[i] = mff[i-1];
    mff[0] = x;
  endfunction

  function automatic void m_clear();
    for (int i = 0; i < 9; i++) mff[i] = 0;
    for (int j = 0; j < 4; j++) mfb[j] = 0;
    mdc = 0;
  endfunction

  function automatic void m_compute(output bit emit, output longint y);
    longint acc, w;
    acc = 0;
    if (!m_iir) begin
      for (int k = 0; k < 9; k++) acc += cf[k] * mff[k];
    end else begin
      for (int k = 0; k < 5; k++) acc += cf[k] * mff[k];
      for (int j = 0; j < 4; j++) acc += (cf[5+j] * mfb[j]) >>> 8;
    end
    y = reduce(acc, 23, 16, m_sat);
    if (m_iir) begin
      w = reduce(acc, 15, 24, m_sat);
      for (int j = 3; j > 0; j--) mfb[j] = mfb[j-1];
      mfb[0] = w;
    end
    emit = (mdc >= m_dec);
    if (emit) mdc = 0; else mdc++;
  endfunction

  task automatic set_cfg(bit iir, bit sat, int dec);
    @(negedge clk);
    cfg_iir = iir; cfg_sat = sat; cfg_dec = 4'(dec);
    m_iir = iir; m_sat = sat; m_dec = dec;
  endtask

  task automatic wcoef(int a, longint v, bit upd);
    @(negedge clk);
    coef_we = 1; coef_addr = 4'(a); coef_wdata = 24'(v);
    @(negedge clk);
    coef_we = 0;
    if (upd) cf[a] = v;
  endtask

  task automatic do_flush(bit upd);
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
    if (upd) m_clear();
  endtask

  // kind: 0 normal, 1 prefill, 2 hold mid-way, 3 off mid-way
  task automatic feed(longint x, int kind, string req);
    bit emit, got, rdy_bad;
    longint y, gy;
    int gc, win, pause;
    emit = 0; y = 0; got = 0; gy = -99999; gc = -1; rdy_bad = 0;
    pause = (kind == 2) ? 20 : 0;
    win = 14 + pause;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_data = 16'(x); prefill = (kind == 1);
    m_push(x);
    if (kind == 0 || kind == 2) m_compute(emit, y);
    @(posedge clk);
    #1 in_valid = 0; prefill = 0;
    for (int c = 0; c < win; c++) begin
      @(negedge clk);
      if (out_valid && !got) begin got = 1; gy = out_data; gc = c; end
      if (kind == 2 && c > 3 && c < 3 + pause && in_ready) rdy_bad = 1;
      if (kind == 3 && c > 3 && c < 8 && in_ready) rdy_bad = 1;
      if (kind == 2 && c == 3) begin fren = 1; frz = 1; end
      if (kind == 2 && c == 3 + pause) begin fren = 0; frz = 0; end
      if (kind == 3 && c == 3) mdis = 1;
      if (kind == 3 && c == 8) mdis = 0;
    end
    if (emit)
      chk(got && gc == 11 + pause && gy == y, req, got ? gy * 100 + gc : -1, y * 100 + 11 + pause);
    else
      chk(!got, req, gy, -99999);
    if (kind >= 2) chk(!rdy_bad, req, rdy_bad, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin : main
    int emits;
    m_clear();
    for (int i = 0; i < 9; i++) cf[i] = 0;
    repeat (4) @(posedge clk);
    #1 rst = 0;
    // R12: reset state
    @(negedge clk);
    chk(out_valid == 0, "R12 out_valid", out_valid, 0);
    chk(in_ready == 1, "R12 in_ready", in_ready, 1);

    // R7: every mode bit combination
    for (int m = 0; m < 8; m++) begin
      @(negedge clk);
      mdis = m[2]; fren = m[1]; frz = m[0];
      #1 chk(in_ready == (!m[2] && (m[1:0] != 2'b11)), "R7 mode decode", in_ready, !m[2] && (m[1:0] != 2'b11));
    end
    @(negedge clk); mdis = 0; fren = 0; frz = 0;

    // R12: history is zero after reset; an impulse gives c[k]*1000 per step
    set_cfg(0, 1, 0);
    for (int k = 0; k < 9; k++) wcoef(k, longint'(k + 1) <<< 19, 1);
    feed(1000, 0, "R12 zero history");
    for (int k = 0; k < 9; k++) feed(0, 0, "R1 impulse");

    // R1: finite response, random coefficients and samples, both overflow modes
    for (int s = 0; s < 2; s++) begin
      set_cfg(0, s[0], 0);
      for (int k = 0; k < 9; k++) wcoef(k, rnd(1 << 20), 1);
      do_flush(1);
      for (int n = 0; n < 30; n++) feed(rnd(32767), 0, "R1 fir stream");
    end

    // R3: rounding sweep with weights 1/2 and 1/4
    for (int h = 0; h < 2; h++) begin
      set_cfg(0, 1, 0);
      for (int k = 0; k < 9; k++) wcoef(k, (k == 0) ? (longint'(1) <<< (22 - h)) : 0, 1);
      do_flush(1);
      for (int x = -40; x <= 40; x++) feed(x, 0, "R3 convergent round");
    end

    // R4: overflow handling, wrap then saturate
    for (int s = 0; s < 2; s++) begin
      set_cfg(0, s[0], 0);
      for (int k = 0; k < 9; k++) wcoef(k, (k < 2) ? (longint'(1) <<< 23) - 1 : 0, 1);
      do_flush(1);
      feed(30000, 0, "R4 overflow");  feed(30000, 0, "R4 overflow");
      feed(-30000, 0, "R4 overflow"); feed(-30000, 0, "R4 overflow");
      feed(16000, 0, "R4 overflow");  feed(17000, 0, "R4 overflow");
      feed(-32768, 0, "R4 overflow"); feed(-32768, 0, "R4 overflow");
    end

    // R2: recursive mode, both overflow modes
    for (int s = 0; s < 2; s++) begin
      set_cfg(1, s[0], 0);
      wcoef(0, 1 << 20, 1); wcoef(1, -(1 << 19), 1); wcoef(2, 1 << 18, 1);
      wcoef(3, 3 << 17, 1); wcoef(4, -(1 << 17), 1);
      wcoef(5, 1 << 22, 1); wcoef(6, -(1 << 20), 1); wcoef(7, 1 << 18, 1);
      wcoef(8, -(1 << 17), 1);
      do_flush(1);
      for (int n = 0; n < 30; n++) feed(rnd(16000), 0, "R2 iir stream");
    end

    // R5: every decimation factor
    for (int d = 0; d < 16; d++) begin
      set_cfg(0, 1, d);
      for (int k = 0; k < 9; k++) wcoef(k, rnd(1 << 20), 1);
      do_flush(1);
      emits = 0;
      for (int n = 0; n < 2 * (d + 1); n++) begin
        if (mdc >= m_dec) emits++;
        feed(rnd(20000), 0, "R5 decimation");
      end
      chk(emits == 2, "R5 emit count", emits, 2);
    end

    // R8: hold mid-computation, recursive mode
    set_cfg(1, 0, 0);
    do_flush(1);
    feed(5000, 0, "R8 before hold");
    feed(-7000, 2, "R8 hold pause");
    feed(300, 0, "R8 after hold");
    // R8/R10: writes and flush ignored during hold
    @(negedge clk); fren = 1; frz = 1;
    wcoef(0, 1 << 22, 0);
    do_flush(0);
    @(negedge clk); fren = 0; frz = 0;
    feed(1200, 0, "R8 hold ignores write and flush");

    // R9: off mid-computation drops the result, coefficient write takes effect
    set_cfg(0, 0, 0);
    do_flush(1);
    feed(4000, 0, "R9 before off");
    feed(-2500, 3, "R9 dropped result");
    @(negedge clk); mdis = 1;
    wcoef(1, 1 << 21, 1);
    @(negedge clk); mdis = 0;
    feed(900, 0, "R9 after off");

    // R10: flush clears history and decimation count
    set_cfg(1, 1, 2);
    feed(8000, 0, "R10 fill");
    feed(-8000, 0, "R10 fill");
    do_flush(1);
    for (int n = 0; n < 6; n++) feed(rnd(10000), 0, "R10 after flush");

    // R11: prefill loads history, no output, decimation count kept
    set_cfg(0, 1, 1);
    do_flush(1);
    feed(1111, 0, "R11 count one");
    for (int n = 0; n < 8; n++) feed(rnd(20000), 1, "R11 prefill silent");
    feed(2222, 0, "R11 output after prefill");
    feed(3333, 0, "R11 next");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule